// File: doc/BRIEF.md
# Quad-SPI Command Phase Sequencer

This block runs one serial-flash transaction over a four-line bidirectional data bus, with an active-low chip select and a serial clock. A host presents a command descriptor together with a one-cycle start strobe. The descriptor holds an operating mode, an instruction byte, an optional 24-bit address, a dummy-clock count, a transfer direction and a byte count. The block captures the descriptor, lowers chip select and clocks out the phases in a fixed order. Each phase is driven on the number of data lines that the mode assigns to it. Phases with nothing to send are skipped.

Write bytes arrive on a byte-wide valid/ready port. The serial clock is held low while the block waits for a byte. Read bytes leave as single-cycle valid pulses. The serial clock is derived from the system clock through a programmable half-period divider. After the last bit, chip select stays high for a programmable number of cycles before busy drops, so the host can issue back-to-back commands without breaking the flash's deselect time.

Top module: `qspi_phase_seq`

## Requirements
- R1: A transaction always runs its phases in this order: instruction, address, dummy, data. The address phase runs only when `addr_en_i` is set. The dummy phase runs only when `dummy_i` is nonzero. The data phase runs only when `data_en_i` is set. The total serial clock count equals the sum of the clocks of the phases that run.
- R2: Lines per phase (instruction/address/data) by `mode_i` code: 0 gives 1/1/1, 1 gives 1/1/2, 2 gives 1/2/2, 3 gives 1/1/4, 4 gives 1/4/4, and 5 gives 4/4/4. Codes 6 and 7 act as code 0. A phase on n lines drives `io_o[n-1:0]`, and `io_oe_o` has exactly those bits set.
- R3: Instruction and address go most significant bit first. On two lines, `io_o[1]` carries the earlier (higher) bit. On four lines, the high nibble goes first. The address phase is always 24 bits.
- R4: The dummy phase lasts exactly `dummy_i` serial clocks, and `io_oe_o` is zero throughout it.
- R5: The data phase moves `len_i + 1` bytes, so `len_i` = 0 means one byte.
- R6: In a write data phase, each byte is taken on a cycle where `wr_valid_i` and `wr_ready_o` are both high. `wr_ready_o` rises once per byte, before the first clock of that byte. While it waits, `sclk_o` holds still.
- R7: In a read data phase, `io_oe_o` is zero. Input is sampled on the rising `sclk_o` edge: from `io_i[1]` on one line, from `io_i[1:0]` on two lines, and from `io_i[3:0]` on four lines, earliest bits most significant. Each completed byte appears on `rd_data_o` with a one-cycle `rd_valid_o` pulse.
- R8: `sclk_o` idles low and is low whenever `cs_no` is high. Outputs change on the falling edge. Each half period of `sclk_o` lasts `presc_i + 1` system clocks, so the high time of a transaction totals clocks × (`presc_i` + 1).
- R9: After the last falling edge, `cs_no` rises and stays high with `busy_o` still high for exactly `csh_i + 1` cycles. Then `busy_o` falls. `cs_no` low implies `busy_o` high.
- R10: A start strobe seen while `busy_o` is low is accepted, and `busy_o` is high on the next cycle. A start strobe while busy is ignored and does not alter the running transaction.
- R11: `io_oe_o` is nonzero only while `cs_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Descriptor valid strobe |
| mode_i | input | 3 | Operating mode code |
| instr_i | input | 8 | Instruction byte |
| addr_en_i | input | 1 | Address phase present |
| addr_i | input | 24 | Address |
| dummy_i | input | DUMMY_W | Dummy clock count |
| read_i | input | 1 | Data direction, 1 = read |
| data_en_i | input | 1 | Data phase present |
| len_i | input | LEN_W | Byte count minus one |
| presc_i | input | DIV_W | Serial clock half period minus one |
| csh_i | input | CSH_W | Chip-select high time minus one |
| wr_data_i | input | 8 | Write byte |
| wr_valid_i | input | 1 | Write byte valid |
| wr_ready_o | output | 1 | Write byte wanted |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | Read byte pulse |
| busy_o | output | 1 | Transaction in progress |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| io_o | output | 4 | Data lines out |
| io_oe_o | output | 4 | Per-line output enable |
| io_i | input | 4 | Data lines in |

## Verification
The checks assume the host raises `start_i` for one cycle and keeps the descriptor stable on that cycle. They also assume `wr_valid_i` rises only while `wr_ready_o` is high and the byte is still owed. The bench drives write bytes from a driver that watches `wr_ready_o`, so it never offers a byte the block did not ask for. It changes `io_i` only on falling serial clock edges, so every sample taken on a rising edge sees settled data. The stray start strobe sent mid-transaction is the only input that breaks the single-strobe habit, and it exists to show that the block ignores it.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;

  // value equals log2 of the line count
  typedef enum logic [1:0] {
    LW1 = 2'd0,
    LW2 = 2'd1,
    LW4 = 2'd2
  } lanes_e;

  typedef struct packed {
    lanes_e instr;
    lanes_e addr;
    lanes_e data;
  } lane_set_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INSTR,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_HOLD
  } state_e;

endpackage

// File: rtl/qspi_lane_sel.sv
module qspi_lane_sel
  import qspi_seq_pkg::*;
(
  input  logic [2:0] mode_i,
  output lane_set_t  lanes_o
);
  always_comb begin
    unique case (mode_i)
      3'd1:    lanes_o = '{instr: LW1, addr: LW1, data: LW2};
      3'd2:    lanes_o = '{instr: LW1, addr: LW2, data: LW2};
      3'd3:    lanes_o = '{instr: LW1, addr: LW1, data: LW4};
      3'd4:    lanes_o = '{instr: LW1, addr: LW4, data: LW4};
      3'd5:    lanes_o = '{instr: LW4, addr: LW4, data: LW4};
      default: lanes_o = '{instr: LW1, addr: LW1, data: LW1};
    endcase
  end
endmodule

// File: rtl/qspi_clkdiv.sv
module qspi_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] presc_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] div_q;
  logic             sclk_q;
  logic             tick;

  assign tick   = run_i && (div_q == presc_i);
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      div_q <= '0;
    end else if (tick) begin
      div_q  <= '0;
      sclk_q <= !sclk_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/qspi_phase_seq.sv
module qspi_phase_seq
  import qspi_seq_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int DUMMY_W = 5,
  parameter int DIV_W   = 8,
  parameter int CSH_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [2:0]         mode_i,
  input  logic [7:0]         instr_i,
  input  logic               addr_en_i,
  input  logic [23:0]        addr_i,
  input  logic [DUMMY_W-1:0] dummy_i,
  input  logic               read_i,
  input  logic               data_en_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [DIV_W-1:0]   presc_i,
  input  logic [CSH_W-1:0]   csh_i,
  input  logic [7:0]         wr_data_i,
  input  logic               wr_valid_i,
  output logic               wr_ready_o,
  output logic [7:0]         rd_data_o,
  output logic               rd_valid_o,
  output logic               busy_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic [3:0]         io_o,
  output logic [3:0]         io_oe_o,
  input  logic [3:0]         io_i
);
  localparam int CNT_W = (DUMMY_W > 5) ? DUMMY_W : 5;

  state_e             state_q, nxt_state;
  logic [2:0]         mode_q;
  logic               addr_en_q, read_q, data_en_q;
  logic [23:0]        addr_q;
  logic [DUMMY_W-1:0] dummy_q;
  logic [LEN_W-1:0]   len_q, bytes_q;
  logic [DIV_W-1:0]   presc_q;
  logic [CSH_W-1:0]   csh_q, hold_q;
  logic [31:0]        sh_q, sh_nx;
  logic [CNT_W-1:0]   cnt_q;
  logic               need_q;
  logic [6:0]         rsh_q;
  logic [7:0]         rd_nx, rd_data_q;
  logic               rd_valid_q;

  lane_set_t lanes;
  lanes_e    cur_w;
  logic [3:0] lane_mask;
  logic       active, run, rise, fall, last_clk, drive;

  // in idle, decode the incoming mode so the first phase loads right
  qspi_lane_sel u_lanes (
    .mode_i (state_q == ST_IDLE ? mode_i : mode_q),
    .lanes_o(lanes)
  );

  qspi_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .presc_i(presc_q),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign active   = (state_q == ST_INSTR) || (state_q == ST_ADDR) ||
                    (state_q == ST_DUMMY) || (state_q == ST_DATA);
  assign run      = active && !((state_q == ST_DATA) && need_q);
  assign last_clk = (cnt_q == CNT_W'(1));

  always_comb begin
    unique case (state_q)
      ST_INSTR: cur_w = lanes.instr;
      ST_ADDR:  cur_w = lanes.addr;
      default:  cur_w = lanes.data;
    endcase
  end

  always_comb begin
    unique case (cur_w)
      LW1: begin
        lane_mask = 4'b0001;
        io_o      = {3'b000, sh_q[31]};
        sh_nx     = {sh_q[30:0], 1'b0};
      end
      LW2: begin
        lane_mask = 4'b0011;
        io_o      = {2'b00, sh_q[31:30]};
        sh_nx     = {sh_q[29:0], 2'b00};
      end
      default: begin
        lane_mask = 4'b1111;
        io_o      = sh_q[31:28];
        sh_nx     = {sh_q[27:0], 4'h0};
      end
    endcase
  end

  always_comb begin
    unique case (lanes.data)
      LW1:     rd_nx = {rsh_q[6:0], io_i[1]};
      LW2:     rd_nx = {rsh_q[5:0], io_i[1:0]};
      default: rd_nx = {rsh_q[3:0], io_i};
    endcase
  end

  // phase skipping chain
  always_comb begin
    state_e after_dummy, after_addr, after_instr;
    after_dummy = data_en_q ? ST_DATA : ST_HOLD;
    after_addr  = (dummy_q != '0) ? ST_DUMMY : after_dummy;
    after_instr = addr_en_q ? ST_ADDR : after_addr;
    unique case (state_q)
      ST_INSTR: nxt_state = after_instr;
      ST_ADDR:  nxt_state = after_addr;
      ST_DUMMY: nxt_state = after_dummy;
      default:  nxt_state = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= '0;
      addr_en_q  <= 1'b0;
      read_q     <= 1'b0;
      data_en_q  <= 1'b0;
      addr_q     <= '0;
      dummy_q    <= '0;
      len_q      <= '0;
      bytes_q    <= '0;
      presc_q    <= '0;
      csh_q      <= '0;
      hold_q     <= '0;
      sh_q       <= '0;
      cnt_q      <= '0;
      need_q     <= 1'b0;
      rsh_q      <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q   <= ST_INSTR;
            mode_q    <= mode_i;
            addr_en_q <= addr_en_i;
            addr_q    <= addr_i;
            dummy_q   <= dummy_i;
            read_q    <= read_i;
            data_en_q <= data_en_i;
            len_q     <= len_i;
            presc_q   <= presc_i;
            csh_q     <= csh_i;
            sh_q      <= {instr_i, 24'h0};
            cnt_q     <= CNT_W'(32'd8 >> lanes.instr);
          end
        end
        ST_HOLD: begin
          if (hold_q == '0) state_q <= ST_IDLE;
          else              hold_q  <= hold_q - 1'b1;
        end
        default: begin
          if ((state_q == ST_DATA) && need_q && wr_valid_i) begin
            sh_q[31:24] <= wr_data_i;
            need_q      <= 1'b0;
          end
          if (rise && (state_q == ST_DATA) && read_q) begin
            rsh_q <= rd_nx[6:0];
            if (last_clk) begin
              rd_data_q  <= rd_nx;
              rd_valid_q <= 1'b1;
            end
          end
          if (fall) begin
            if (!last_clk) begin
              cnt_q <= cnt_q - 1'b1;
              sh_q  <= sh_nx;
            end else if ((state_q == ST_DATA) && (bytes_q != '0)) begin
              bytes_q <= bytes_q - 1'b1;
              cnt_q   <= CNT_W'(32'd8 >> lanes.data);
              need_q  <= !read_q;
            end else begin
              state_q <= nxt_state;
              unique case (nxt_state)
                ST_ADDR: begin
                  sh_q  <= {addr_q, 8'h00};
                  cnt_q <= CNT_W'(32'd24 >> lanes.addr);
                end
                ST_DUMMY: cnt_q <= CNT_W'(dummy_q);
                ST_DATA: begin
                  cnt_q   <= CNT_W'(32'd8 >> lanes.data);
                  bytes_q <= len_q;
                  need_q  <= !read_q;
                end
                default: hold_q <= csh_q;
              endcase
            end
          end
        end
      endcase
    end
  end

  assign drive      = (state_q == ST_INSTR) || (state_q == ST_ADDR) ||
                      ((state_q == ST_DATA) && !read_q);
  assign io_oe_o    = drive ? lane_mask : 4'b0000;
  assign cs_no      = !active;
  assign busy_o     = (state_q != ST_IDLE);
  assign wr_ready_o = (state_q == ST_DATA) && need_q;
  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;

endmodule

// File: rtl/qspi_phase_seq_chk.sv
module qspi_phase_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       cs_no,
  input logic       sclk_o,
  input logic [3:0] io_oe_o,
  input logic       wr_ready_o,
  input logic       wr_valid_i,
  input logic       rd_valid_o
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) cs_no |-> !sclk_o); // R8
  AST_CS_IMPLIES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) !cs_no |-> busy_o); // R9
  AST_BUSY_FALL_AFTER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy_o) |-> $past(cs_no)); // R9
  AST_OE_ONLY_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni) (io_oe_o != 4'b0000) |-> !cs_no); // R11
  AST_WR_WAIT_HOLDS_SCLK: assert property (@(posedge clk_i) disable iff (!rst_ni) (wr_ready_o && !wr_valid_i) |=> $stable(sclk_o)); // R6
  AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) (start_i && !busy_o) |=> busy_o); // R10
  AST_RD_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) rd_valid_o |=> !rd_valid_o); // R7
endmodule

bind qspi_phase_seq qspi_phase_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .cs_no     (cs_no),
  .sclk_o    (sclk_o),
  .io_oe_o   (io_oe_o),
  .wr_ready_o(wr_ready_o),
  .wr_valid_i(wr_valid_i),
  .rd_valid_o(rd_valid_o)
);

// File: tb/qspi_phase_seq_tb.sv
module qspi_phase_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [7:0]  instr_i = '0;
  logic        addr_en_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [4:0]  dummy_i = '0;
  logic        read_i = 1'b0;
  logic        data_en_i = 1'b0;
  logic [7:0]  len_i = '0;
  logic [7:0]  presc_i = '0;
  logic [3:0]  csh_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        wr_valid_i = 1'b0;
  logic        wr_ready_o, rd_valid_o, busy_o, sclk_o, cs_no;
  logic [7:0]  rd_data_o;
  logic [3:0]  io_o, io_oe_o;
  logic [3:0]  io_i = '0;

  always #4 clk = !clk;

  qspi_phase_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .instr_i(instr_i), .addr_en_i(addr_en_i), .addr_i(addr_i),
    .dummy_i(dummy_i), .read_i(read_i), .data_en_i(data_en_i),
    .len_i(len_i), .presc_i(presc_i), .csh_i(csh_i),
    .wr_data_i(wr_data_i), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .busy_o(busy_o),
    .sclk_o(sclk_o), .cs_no(cs_no), .io_o(io_o), .io_oe_o(io_oe_o),
    .io_i(io_i)
  );

  int nchk = 0, nbad = 0;
  logic [3:0] cap_io [0:1023];
  logic [3:0] cap_oe [0:1023];
  logic [3:0] exp_io [0:1023];
  logic [3:0] exp_oe [0:1023];
  int ncap = 0, ne = 0;
  int hi_cnt = 0, hold_cnt = 0, stall_cnt = 0;
  logic [7:0] rd_got [0:63];
  int nrd = 0;
  logic [7:0] wbytes [0:63];
  bit wen = 1'b0, acc_pend = 1'b0;
  int widx = 0, wlen = 0, gap = 0, wait_cnt = 0;

  function automatic logic [3:0] resp(int j);
    return 4'((j * 5 + 9) ^ (j >> 2));
  endfunction

  function automatic int iw(int m);  return (m == 5) ? 4 : 1; endfunction
  function automatic int aw(int m);
    return (m == 2) ? 2 : ((m == 4 || m == 5) ? 4 : 1);
  endfunction
  function automatic int dw(int m);
    return (m == 1 || m == 2) ? 2 : ((m >= 3 && m <= 5) ? 4 : 1);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add(int val, int nbits, int w, bit drv);
    for (int k = 0; k < nbits / w; k++) begin
      exp_io[ne] = 4'((val >> (nbits - w * (k + 1))) & ((1 << w) - 1));
      exp_oe[ne] = drv ? 4'((1 << w) - 1) : 4'h0;
      ne++;
    end
  endtask

  // bus monitor and read responder
  always @(posedge sclk_o) if (!cs_no && ncap < 1024) begin
    cap_io[ncap] = io_o;
    cap_oe[ncap] = io_oe_o;
    ncap++;
  end
  always @(negedge sclk_o) io_i = resp(ncap);

  always @(negedge clk) begin
    if (!cs_no && sclk_o) hi_cnt++;
    if (cs_no && busy_o) hold_cnt++;
    if (rd_valid_o && nrd < 64) begin rd_got[nrd] = rd_data_o; nrd++; end
    if (wr_ready_o) stall_cnt++;
    if (acc_pend) begin widx++; acc_pend = 1'b0; wait_cnt = 0; end
    wr_data_i  = wbytes[widx & 63];
    wr_valid_i = wen && (widx < wlen) && (wait_cnt >= gap) && wr_ready_o;
    if (wr_valid_i) acc_pend = 1'b1;
    else if (wr_ready_o) wait_cnt++;
  end

  task automatic run_txn(string tag, int mode, int ins, bit aen, int addr,
                         int dum, bit rd, bit den, int len, int presc,
                         int csh, int g, bit poke);
    int bad, first, d0, nbw;
    ne = 0;
    add(ins, 8, iw(mode), 1'b1);
    if (aen) add(addr, 24, aw(mode), 1'b1);
    for (int k = 0; k < dum; k++) add(0, 1, 1, 1'b0);
    for (int b = 0; b < 64; b++) wbytes[b] = 8'((b * 37 + 5) ^ ins);
    if (den) for (int b = 0; b <= len; b++)
      add(rd ? 0 : int'(wbytes[b]), 8, dw(mode), !rd);
    ncap = 0; hi_cnt = 0; hold_cnt = 0; stall_cnt = 0; nrd = 0;
    widx = 0; wait_cnt = 0; acc_pend = 1'b0; gap = g;
    wlen = den ? len + 1 : 0; wen = den && !rd;
    io_i = resp(0);
    @(negedge clk);
    mode_i = 3'(mode); instr_i = 8'(ins); addr_en_i = aen; addr_i = 24'(addr);
    dummy_i = 5'(dum); read_i = rd; data_en_i = den; len_i = 8'(len);
    presc_i = 8'(presc); csh_i = 4'(csh); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    instr_i = '0; addr_i = '0; mode_i = 3'd5;
    chk(busy_o == 1'b1, "R10", {tag, " busy after start"}, int'(busy_o), 1);
    if (poke) begin
      repeat (7) @(negedge clk);
      instr_i = 8'(~ins); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    wen = 1'b0;
    chk(ncap == ne, "R1", {tag, " serial clock count"}, ncap, ne);
    bad = 0; first = -1;
    for (int j = 0; j < ne && j < ncap; j++) begin
      if (cap_oe[j] != exp_oe[j] ||
          (exp_oe[j] != 0 && cap_io[j] != exp_io[j])) begin
        bad++;
        if (first < 0) first = j;
      end
    end
    if (first < 0) chk(1'b1, "R2", {tag, " line stream"}, 0, 0);
    else chk(1'b0, "R2", {tag, " line stream io/oe at first bad clock"},
             int'({cap_oe[first], cap_io[first]}), int'({exp_oe[first], exp_io[first]}));
    chk(hi_cnt == ne * (presc + 1), "R8", {tag, " sclk high cycles"}, hi_cnt, ne * (presc + 1));
    chk(hold_cnt == csh + 1, "R9", {tag, " cs high hold"}, hold_cnt, csh + 1);
    if (den && rd) begin
      chk(nrd == len + 1, "R5", {tag, " read byte count"}, nrd, len + 1);
      d0 = 8 / iw(mode) + (aen ? 24 / aw(mode) : 0) + dum;
      nbw = 8 / dw(mode);
      for (int b = 0; b <= len && b < nrd; b++) begin
        int v;
        v = 0;
        for (int k = 0; k < nbw; k++) begin
          logic [3:0] r;
          r = resp(d0 + b * nbw + k);
          if (dw(mode) == 1) v = (v << 1) | int'(r[1]);
          else v = (v << dw(mode)) | (int'(r) & ((1 << dw(mode)) - 1));
        end
        chk(rd_got[b] == 8'(v), "R7", {tag, " read byte"}, int'(rd_got[b]), v);
      end
    end else begin
      chk(nrd == 0, "R7", {tag, " no read pulses"}, nrd, 0);
    end
    if (den && !rd) begin
      chk(widx == len + 1, "R5", {tag, " write bytes taken"}, widx, len + 1);
      chk(stall_cnt == (g + 1) * (len + 1), "R6", {tag, " ready cycles"},
          stall_cnt, (g + 1) * (len + 1));
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(cs_no == 1'b1, "R9", "reset cs", int'(cs_no), 1);
    chk(busy_o == 1'b0, "R10", "reset busy", int'(busy_o), 0);
    chk(sclk_o == 1'b0, "R8", "reset sclk", int'(sclk_o), 0);
    chk(io_oe_o == 4'h0, "R11", "reset oe", int'(io_oe_o), 0);
    chk(wr_ready_o == 1'b0, "R6", "reset ready", int'(wr_ready_o), 0);
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    // R1 instruction only
    run_txn("cmd_only", 0, 8'h06, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0);
    // R3 R10 one-line read, stray start mid-run
    run_txn("std_read", 0, 8'h03, 1, 24'h12A5C3, 0, 1, 1, 2, 1, 0, 0, 1);
    // R4 four-line data, eight dummy clocks
    run_txn("qout_read", 3, 8'h6B, 1, 24'h00F00D, 8, 1, 1, 1, 0, 5, 0, 0);
    // R6 four-line address and data write with producer stalls
    run_txn("qio_write", 4, 8'h32, 1, 24'hA1B2C3, 0, 0, 1, 3, 1, 1, 2, 0);
    // R2 all phases four-line, single byte (R5 len zero)
    run_txn("qall_read", 5, 8'hEB, 1, 24'h7E5A19, 2, 1, 1, 0, 2, 3, 0, 0);
    // R2 two-line write without address
    run_txn("dio_write", 2, 8'hA2, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    // R2 two-line read data only
    run_txn("dout_read", 1, 8'h3B, 1, 24'h800001, 8, 1, 1, 1, 0, 1, 0, 0);
    // R2 code 7 acts as one-line, R7 samples line 1
    run_txn("code7_read", 7, 8'h9F, 0, 0, 0, 1, 1, 2, 0, 0, 0, 0);
    // R11 idle after traffic
    chk(io_oe_o == 4'h0, "R11", "idle oe", int'(io_oe_o), 0);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule